// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences conversions for an external analog-to-digital converter. Software fills up to eight configuration slots with channel numbers. It sets a first and a last slot, a first buffer index, an interval rule and a mode, then writes a start command. The controller walks the slot range. For each slot it sends a one-cycle start request, together with that slot's channel, to the converter. It then waits for the converter's done strobe and stores the returned result in a 16-entry sample buffer.

After each stored result, a data-available flag can be set according to one of four interval rules. The flag is sticky, and it drives an interrupt line when the interrupt is enabled. In single mode the controller stops after the last slot. In continuous mode it loops back to the first slot until software stops it. The configuration fields cannot be changed while a sequence runs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, registers 0, 1 and 2 read 0, and irq_o and conv_start_o are 0.
- R2: The register map is as follows. Unused bits read 0.
  - Address 0: store index in bits 11:8, first slot in bits 6:4, last slot in bits 2:0.
  - Address 1: interval code in bits 11:10, continuous mode in bit 6, interrupt enable in bit 5.
  - Address 2: status. Busy is bit 0 and the flag is bit 1.
  - Addresses 8+k: the channel of slot k, in bits 3:0.
  - Addresses 16+i: buffer entry i, in bits 11:0.
- R3: Writing address 2 with bit 0 = 1 while idle starts a sequence. Each conversion is requested by a single-cycle conv_start_o pulse carrying conv_chan_o, the channel of the current slot. The next request follows only after conv_done_i.
- R4: Slots are used from the first slot to the last slot, both inclusive. When the last slot is below the first, the walk wraps from 7 to 0. In single mode, busy clears once the last slot's result is stored.
- R5: Results are written to the buffer from the store index upward, one entry per result, wrapping from 15 to 0.
- R6: In continuous mode, the walk returns to the first slot after the last. Writing address 2 with bit 0 = 0 while busy stops the sequence at once, and a later done strobe stores nothing.
- R7: Interval code 00 sets the flag on every stored result.
- R8: Interval code 01 sets the flag only when the last slot's result is stored in single mode. It never sets the flag in continuous mode.
- R9: Interval code 10 sets the flag on every 12th stored result and code 11 on every 16th. The sample count restarts at each start command.
- R10: The flag stays set until address 2 is written with bit 1 = 0. Writing bit 1 = 1 leaves it unchanged. irq_o is the flag ANDed with the interrupt enable.
- R11: Writes to address 0, address 1 and the slot registers are ignored while busy. Writing bit 0 = 1 to address 2 while busy does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 4 | Channel for the requested conversion |
| conv_done_i | input | 1 | Conversion done strobe |
| conv_data_i | input | 12 | Conversion result, valid with conv_done_i |
| irq_o | output | 1 | Data-available interrupt |

## Verification
The assertions check the following on every cycle:
- the start request lasts a single cycle and never appears while idle;
- the slot index steps by one, or returns to the first slot after the last in continuous mode;
- the buffer index advances by one per stored result;
- the address fields hold during a busy write;
- the flag stays set until cleared.

Only the bench scenarios show the rest. These are the exact slot order of a wrapped range, the buffer contents at the wrapped indices, and whether the flag sets on the 12th or the 16th result. They also show the sample count restarting after a restart, the silence of code 01 in continuous mode, and the dropped result after a stop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    IV_EACH = 2'd0,
    IV_SEQ  = 2'd1,
    IV_12   = 2'd2,
    IV_16   = 2'd3
  } ival_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

  localparam int unsigned RW = 16;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOT_AW = 3,
  parameter int unsigned BUF_AW  = 4,
  parameter int unsigned CH_W    = 4,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned NSLOT  = 1 << SLOT_AW
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [RW-1:0]                   wdata_i,
  input  logic                            busy_i,
  output logic [SLOT_AW-1:0]              start_idx_o,
  output logic [SLOT_AW-1:0]              end_idx_o,
  output logic [BUF_AW-1:0]               store_idx_o,
  output ival_e                           ival_o,
  output logic                            cont_o,
  output logic                            ie_o,
  output logic [NSLOT-1:0][CH_W-1:0]      slot_ch_o
);
  logic wr_ok;
  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_idx_o <= '0;
      end_idx_o   <= '0;
      store_idx_o <= '0;
      ival_o      <= IV_EACH;
      cont_o      <= 1'b0;
      ie_o        <= 1'b0;
      slot_ch_o   <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_W'(0)) begin
        store_idx_o <= wdata_i[8 +: BUF_AW];
        start_idx_o <= wdata_i[4 +: SLOT_AW];
        end_idx_o   <= wdata_i[0 +: SLOT_AW];
      end else if (addr_i == ADDR_W'(1)) begin
        ival_o <= ival_e'(wdata_i[11:10]);
        cont_o <= wdata_i[6];
        ie_o   <= wdata_i[5];
      end else if (addr_i[ADDR_W-1:SLOT_AW] == (ADDR_W-SLOT_AW)'(1)) begin
        slot_ch_o[addr_i[SLOT_AW-1:0]] <= wdata_i[CH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOT_AW = 3,
  parameter int unsigned BUF_AW  = 4,
  parameter int unsigned CH_W    = 4,
  localparam int unsigned NSLOT  = 1 << SLOT_AW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_cmd_i,
  input  logic                       stop_cmd_i,
  input  logic [SLOT_AW-1:0]         start_idx_i,
  input  logic [SLOT_AW-1:0]         end_idx_i,
  input  logic [BUF_AW-1:0]          store_idx_i,
  input  logic                       cont_i,
  input  logic [NSLOT-1:0][CH_W-1:0] slot_ch_i,
  input  logic                       conv_done_i,
  output logic                       busy_o,
  output logic                       conv_start_o,
  output logic [CH_W-1:0]            conv_chan_o,
  output logic                       wr_en_o,
  output logic [BUF_AW-1:0]          wr_idx_o,
  output logic [SLOT_AW-1:0]         cfg_idx_o,
  output logic                       last_o,
  output logic                       seq_start_o
);
  st_e               st_q;
  logic [SLOT_AW-1:0] cfg_q;
  logic [BUF_AW-1:0]  bidx_q;
  logic               accept;

  assign accept = (st_q == ST_WAIT) && conv_done_i && !stop_cmd_i;
  assign last_o = (cfg_q == end_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      bidx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_cmd_i) begin
          st_q   <= ST_REQ;
          cfg_q  <= start_idx_i;
          bidx_q <= store_idx_i;
        end
        default: begin
          if (stop_cmd_i) begin
            st_q <= ST_IDLE;
          end else if (st_q == ST_REQ) begin
            st_q <= ST_WAIT;
          end else if (accept) begin
            bidx_q <= bidx_q + 1'b1;
            if (last_o) begin
              if (cont_i) begin
                cfg_q <= start_idx_i;
                st_q  <= ST_REQ;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              cfg_q <= cfg_q + 1'b1;
              st_q  <= ST_REQ;
            end
          end
        end
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign conv_start_o = (st_q == ST_REQ);
  assign conv_chan_o  = slot_ch_i[cfg_q];
  assign wr_en_o      = accept;
  assign wr_idx_o     = bidx_q;
  assign cfg_idx_o    = cfg_q;
  assign seq_start_o  = (st_q == ST_IDLE) && start_cmd_i;
endmodule

// File: rtl/adc_seq_flag.sv
module adc_seq_flag
  import adc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  seq_start_i,
  input  logic  sample_i,
  input  logic  last_i,
  input  logic  cont_i,
  input  ival_e ival_i,
  input  logic  clr_i,
  output logic  flag_o
);
  localparam int unsigned CNT_W = 4;
  logic [CNT_W-1:0] cnt_q;
  logic hit, set;

  always_comb begin
    unique case (ival_i)
      IV_12:   hit = (cnt_q == CNT_W'(11));
      IV_16:   hit = (cnt_q == CNT_W'(15));
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ival_i)
      IV_EACH: set = sample_i;
      IV_SEQ:  set = sample_i && last_i && !cont_i;
      default: set = sample_i && hit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (seq_start_i)   cnt_q <= '0;
      else if (sample_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      // a new result wins over a clear in the same cycle
      if (set)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_buf.sv
module adc_seq_buf #(
  parameter int unsigned BUF_AW = 4,
  parameter int unsigned DW     = 12,
  localparam int unsigned NBUF  = 1 << BUF_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BUF_AW-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [BUF_AW-1:0] ridx_i,
  output logic [DW-1:0]     rdata_o
);
  logic [NBUF-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOT_AW = 3,
  parameter int unsigned BUF_AW  = 4,
  parameter int unsigned CH_W    = 4,
  parameter int unsigned DW      = 12,
  localparam int unsigned NSLOT  = 1 << SLOT_AW,
  localparam int unsigned ADDR_W = BUF_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  output logic [RW-1:0]     reg_rdata_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DW-1:0]     conv_data_i,
  output logic              irq_o
);
  logic [SLOT_AW-1:0]         start_idx, end_idx, cfg_idx;
  logic [BUF_AW-1:0]          store_idx, wr_idx;
  ival_e                      ival;
  logic                       cont, ie, busy, flag, wr_en, last, seq_start;
  logic [NSLOT-1:0][CH_W-1:0] slot_ch;
  logic [DW-1:0]              buf_rd;
  logic                       stat_we, start_cmd, stop_cmd, clr_flag;

  assign stat_we   = reg_we_i && (reg_addr_i == ADDR_W'(2));
  assign start_cmd = stat_we && reg_wdata_i[0] && !busy;
  assign stop_cmd  = stat_we && !reg_wdata_i[0] && busy;
  assign clr_flag  = stat_we && !reg_wdata_i[1];

  adc_seq_regs #(.SLOT_AW(SLOT_AW), .BUF_AW(BUF_AW), .CH_W(CH_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .busy_i(busy),
    .start_idx_o(start_idx), .end_idx_o(end_idx), .store_idx_o(store_idx),
    .ival_o(ival), .cont_o(cont), .ie_o(ie), .slot_ch_o(slot_ch)
  );

  adc_seq_fsm #(.SLOT_AW(SLOT_AW), .BUF_AW(BUF_AW), .CH_W(CH_W)) i_fsm (
    .clk_i, .rst_ni,
    .start_cmd_i(start_cmd), .stop_cmd_i(stop_cmd),
    .start_idx_i(start_idx), .end_idx_i(end_idx), .store_idx_i(store_idx),
    .cont_i(cont), .slot_ch_i(slot_ch), .conv_done_i,
    .busy_o(busy), .conv_start_o, .conv_chan_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .cfg_idx_o(cfg_idx),
    .last_o(last), .seq_start_o(seq_start)
  );

  adc_seq_flag i_flag (
    .clk_i, .rst_ni,
    .seq_start_i(seq_start), .sample_i(wr_en), .last_i(last),
    .cont_i(cont), .ival_i(ival), .clr_i(clr_flag), .flag_o(flag)
  );

  adc_seq_buf #(.BUF_AW(BUF_AW), .DW(DW)) i_buf (
    .clk_i, .rst_ni,
    .we_i(wr_en), .widx_i(wr_idx), .wdata_i(conv_data_i),
    .ridx_i(reg_addr_i[BUF_AW-1:0]), .rdata_o(buf_rd)
  );

  assign irq_o = flag && ie;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1]) begin
      reg_rdata_o[DW-1:0] = buf_rd;
    end else if (reg_addr_i[ADDR_W-1:SLOT_AW] == (ADDR_W-SLOT_AW)'(1)) begin
      reg_rdata_o[CH_W-1:0] = slot_ch[reg_addr_i[SLOT_AW-1:0]];
    end else begin
      unique case (reg_addr_i)
        ADDR_W'(0): begin
          reg_rdata_o[8 +: BUF_AW]  = store_idx;
          reg_rdata_o[4 +: SLOT_AW] = start_idx;
          reg_rdata_o[0 +: SLOT_AW] = end_idx;
        end
        ADDR_W'(1): begin
          reg_rdata_o[11:10] = ival;
          reg_rdata_o[6]     = cont;
          reg_rdata_o[5]     = ie;
        end
        ADDR_W'(2): reg_rdata_o[1:0] = {flag, busy};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned SLOT_AW = 3,
  parameter int unsigned BUF_AW  = 4,
  parameter int unsigned ADDR_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               conv_start_o,
  input logic               busy,
  input logic [SLOT_AW-1:0] cfg_idx,
  input logic [SLOT_AW-1:0] start_idx,
  input logic [SLOT_AW-1:0] end_idx,
  input logic [BUF_AW-1:0]  store_idx,
  input logic [BUF_AW-1:0]  wr_idx,
  input logic               wr_en,
  input logic               cont,
  input logic               flag,
  input logic               clr_flag
);
  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!conv_start_o && !wr_en));

  assert_slot_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cfg_idx != end_idx) |=> cfg_idx == SLOT_AW'($past(cfg_idx) + 1'b1));

  assert_buf_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> wr_idx == BUF_AW'($past(wr_idx) + 1'b1));

  assert_cont_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && cfg_idx == end_idx && cont) |=> (cfg_idx == start_idx && busy));

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !clr_flag) |=> flag);

  assert_addr_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == '0) |=> $stable({store_idx, start_idx, end_idx}));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOT_AW(SLOT_AW), .BUF_AW(BUF_AW), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/100ps
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq;

  int total = 0, fails = 0;
  int start_cnt = 0, served = 0;
  logic [3:0] last_ch = '0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .irq_o(irq)
  );

  // converter model: remember each request
  always @(posedge clk)
    if (rst_n && conv_start) begin
      start_cnt <= start_cnt + 1;
      last_ch   <= conv_chan;
    end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wdata = 16'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 5'(a);
    #0.1;
    v = int'(reg_rdata);
  endtask

  task automatic serve(input int exp_ch, input int d, input string tag);
    while (start_cnt <= served) @(negedge clk);
    served++;
    chk(tag, int'(last_ch), exp_ch);
    conv_done = 1'b1; conv_data = 12'(d);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic flag_is(input int exp, input string tag);
    int v;
    rd(2, v);
    chk(tag, (v >> 1) & 1, exp);
  endtask

  task automatic t_reset;
    int v;
    rd(0, v); chk("R1 addr reg", v, 0);
    rd(1, v); chk("R1 ctrl reg", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 start", int'(conv_start), 0);
  endtask

  task automatic t_layout;
    int v;
    wr(0, 16'hFFFF); rd(0, v); chk("R2 addr fields", v, 16'h0F77);
    wr(1, 16'hFFFF); rd(1, v); chk("R2 ctrl fields", v, 16'h0C60);
    for (int k = 0; k < 8; k++) wr(8 + k, 16'hFFF0 | (k + 3));
    rd(13, v); chk("R2 slot 5", v, 8);
  endtask

  // single, code 00, buffer wrap, locked writes
  task automatic t_single_each;
    int v;
    wr(0, 16'h0E25);          // store 14, first 2, last 5
    wr(1, 16'h0020);          // code 00, ie
    wr(2, 16'h0000);
    wr(2, 16'h0003);
    rd(2, v); chk("R3 busy after start", v & 1, 1);
    wr(0, 16'h0777); rd(0, v); chk("R11 addr locked", v, 16'h0E25);
    wr(1, 16'h0C40); rd(1, v); chk("R11 ctrl locked", v, 16'h0020);
    wr(10, 16'h0009); rd(10, v); chk("R11 slot locked", v, 5);
    for (int i = 0; i < 4; i++) begin
      serve(2 + i + 3, 16'h100 + i, "R3 channel order");
      flag_is(1, "R7 flag per result");
      chk("R10 irq follows flag", int'(irq), 1);
      if (i < 3) begin
        wr(2, 16'h0001);      // clear; start bit ignored while busy
        flag_is(0, "R10 clear");
        rd(2, v); chk("R11 no restart", v & 1, 1);
      end
    end
    rd(2, v); chk("R4 idle after last", v & 1, 0);
    rd(30, v); chk("R5 buf 14", v, 16'h100);
    rd(31, v); chk("R5 buf 15", v, 16'h101);
    rd(16, v); chk("R5 buf wrap 0", v, 16'h102);
    rd(17, v); chk("R5 buf 1", v, 16'h103);
    wr(2, 16'h0000);
  endtask

  // single, code 01, slot range wraps through 7
  task automatic t_single_seq_wrap;
    int v;
    int chs[4] = '{9, 10, 3, 4};
    wr(0, 16'h0461);          // store 4, first 6, last 1
    wr(1, 16'h0420);
    wr(2, 16'h0000);
    wr(2, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      serve(chs[i], 16'h200 + i, "R4 wrapped slot order");
      if (i < 3) flag_is(0, "R8 no flag mid sequence");
    end
    flag_is(1, "R8 flag at end");
    rd(2, v); chk("R4 idle", v & 1, 0);
    chk("R10 irq", int'(irq), 1);
    rd(23, v); chk("R5 buf 7", v, 16'h203);
    wr(2, 16'h0002);
    flag_is(1, "R10 bit1=1 keeps flag");
    wr(2, 16'h0000);
    flag_is(0, "R10 cleared");
    chk("R10 irq low", int'(irq), 0);
  endtask

  // continuous, code 01 silent, stop drops pending result
  task automatic t_cont_stop;
    int v, sc;
    int chs[3] = '{3, 4, 3};
    wr(0, 16'h0001);          // store 0, first 0, last 1
    wr(1, 16'h0460);
    wr(2, 16'h0003);
    for (int i = 0; i < 3; i++) begin
      serve(chs[i], 16'h300 + i, "R6 loops to first slot");
      flag_is(0, "R8 silent in continuous");
    end
    rd(18, v); chk("R6 buf 2", v, 16'h302);
    while (start_cnt <= served) @(negedge clk);
    wr(2, 16'h0002);          // stop
    served = start_cnt;
    rd(2, v); chk("R6 stopped", v & 1, 0);
    conv_done = 1'b1; conv_data = 12'hABC;
    @(negedge clk); conv_done = 1'b0;
    rd(19, v); chk("R6 late done dropped", v, 0);
    sc = start_cnt;
    repeat (8) @(negedge clk);
    chk("R6 no request after stop", start_cnt, sc);
  endtask

  task automatic run_count(input int n, input int period, input string tag);
    for (int i = 1; i <= n; i++) begin
      serve((i - 1) % 8 + 3, i, tag);
      flag_is((i % period == 0) ? 1 : 0, tag);
      wr(2, 16'h0001);
    end
  endtask

  task automatic stop_now;
    while (start_cnt <= served) @(negedge clk);
    wr(2, 16'h0002);
    served = start_cnt;
  endtask

  // codes 10 and 11, counter restarts on start
  task automatic t_intervals;
    wr(0, 16'h0007);          // first 0, last 7
    wr(1, 16'h0860);
    wr(2, 16'h0000);
    wr(2, 16'h0003);
    run_count(24, 12, "R9 every 12");
    stop_now();
    wr(1, 16'h0C60);
    wr(2, 16'h0000);
    wr(2, 16'h0003);
    run_count(5, 16, "R9 partial run");
    stop_now();
    wr(2, 16'h0003);
    run_count(16, 16, "R9 every 16 after restart");
    stop_now();
  endtask

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_single_each();
    t_single_seq_wrap();
    t_cont_stop();
    t_intervals();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule